// File: doc/BRIEF.md
# Stereo Playback/Capture Audio Mixer

This block combines two stereo audio sources into one stereo stream. One source is a playback stream fetched from memory. The other is a capture stream from an analog front end. Each source arrives as separate left and right AXI4-Stream lanes of 24-bit signed samples. The block returns a single AXI4-Stream output that carries left and right results in turn. The channel of each beat is marked on the TID sideband.

A processor-driven enable chooses the mode. With the enable set, each playback sample is added to the capture sample of the same channel. The 25-bit sum is then scaled by a fixed Q1.15 gain of 23198/32768 (about -3 dB) and clipped to 24 bits. With the enable clear, the capture sample goes through unchanged, and the playback lane of the current channel is drained and its data thrown away. The enable is read only when a left sample is accepted, so both halves of a stereo pair always use the same mode. All handshakes honour backpressure, and no accepted sample is dropped.

Top module: `stereo_mix_top`

## Requirements
- R1: After reset the output is not valid, and the block waits for a left sample: the left capture ready is high and the right capture ready is low.
- R2: In mix mode, each result equals floor(((playback + capture) * 23198) / 32768), computed on signed two's-complement values.
- R3: In mix mode, a scaled result above 8388607 is clipped to 8388607, and one below -8388608 is clipped to -8388608.
- R4: In bypass mode, the result equals the capture sample bit for bit.
- R5: In bypass mode, the playback ready of the current channel is held high even while the output is stalled, and its data has no effect on the result.
- R6: In mix mode, a channel's capture sample is not consumed and no output is produced until that channel's playback sample is also valid.
- R7: Output TID is 0 for left and 1 for right, and beats alternate strictly, starting with left after reset.
- R8: The mode chosen by the enable when a left sample is accepted also applies to the following right sample, whatever the enable does in between.
- R9: While the output is valid and not ready, TID and data stay stable. The next sample is not accepted until the held beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mix_en | input | 1 | Processor control: 1 = add playback to capture, 0 = bypass |
| pb_l_tdata | input | 24 | Left playback sample |
| pb_l_tvalid | input | 1 | Left playback valid |
| pb_l_tready | output | 1 | Left playback ready |
| pb_r_tdata | input | 24 | Right playback sample |
| pb_r_tvalid | input | 1 | Right playback valid |
| pb_r_tready | output | 1 | Right playback ready |
| cap_l_tdata | input | 24 | Left capture sample |
| cap_l_tvalid | input | 1 | Left capture valid |
| cap_l_tready | output | 1 | Left capture ready |
| cap_r_tdata | input | 24 | Right capture sample |
| cap_r_tvalid | input | 1 | Right capture valid |
| cap_r_tready | output | 1 | Right capture ready |
| m_tdata | output | 24 | Merged output sample |
| m_tid | output | 1 | Channel of output beat (0 left, 1 right) |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |

## Verification
The main path is tried with small values of opposite sign and with mid-scale values. Small opposite-sign values separate floor rounding from truncation toward zero, and mid-scale values confirm the gain with no clipping. Full-scale pairs of the same sign show that clipping works in both directions, and a max-plus-min pair shows the wrap-free sum of -1. Bypass pairs with large or negative capture values and nonzero playback data show that playback is ignored. Directed runs then change the enable between the halves of a pair, withhold playback in mix mode, and stall the output, to tell apart the mode latch, the join of both inputs, and the hold under backpressure.

// File: rtl/stmix_pkg.sv
// Package: shared constants and channel type for the stereo mixer.
// Assumes Q1.15 gain constant; 23198/32768 approximates -3 dB.
package stmix_pkg;
    localparam int SAMPLE_W  = 24;
    localparam int GAIN_FRAC = 15;
    localparam int GAIN_Q    = 23198;
    localparam int NUM_CH    = 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/stmix_lane.sv
// Module: per-channel arithmetic. In mix mode it adds the two samples at
// one extra bit, scales by a Q1.(GAIN_FRAC) constant with floor rounding
// and clips to the sample width. In bypass it forwards the capture sample.
// Assumes GAIN_Q is positive and below 2**GAIN_FRAC. Purely combinational.
module stmix_lane #(
    parameter int DATA_W    = stmix_pkg::SAMPLE_W,
    parameter int GAIN_FRAC = stmix_pkg::GAIN_FRAC,
    parameter int GAIN_Q    = stmix_pkg::GAIN_Q
) (
    input  logic              mix,
    input  logic [DATA_W-1:0] pb_data,
    input  logic [DATA_W-1:0] cap_data,
    output logic [DATA_W-1:0] result
);
    localparam int SUM_W  = DATA_W + 1;
    localparam int GAIN_W = GAIN_FRAC + 1;
    localparam int PROD_W = SUM_W + GAIN_W;
    localparam int HI_W   = PROD_W - DATA_W + 1;
    localparam logic [GAIN_W-1:0] GAIN_BITS = GAIN_W'(GAIN_Q);

    logic signed [SUM_W-1:0]  sum;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic        [HI_W-1:0]   hi_bits;
    logic                     fits;
    logic        [DATA_W-1:0] clipped;

    // Widened signed sum of the two samples.
    always_comb sum = $signed({pb_data[DATA_W-1], pb_data}) + $signed({cap_data[DATA_W-1], cap_data});

    // Signed multiply by the gain, then arithmetic shift (floor).
    always_comb begin
        prod   = $signed({{GAIN_W{sum[SUM_W-1]}}, sum}) * $signed({{SUM_W{1'b0}}, GAIN_BITS});
        scaled = prod >>> GAIN_FRAC;
    end

    // Clip to the sample range when the upper bits are not a sign extension.
    always_comb begin
        hi_bits = scaled[PROD_W-1:DATA_W-1];
        fits    = (&hi_bits) | ~(|hi_bits);
        if (fits)
            clipped = scaled[DATA_W-1:0];
        else if (scaled[PROD_W-1])
            clipped = {1'b1, {(DATA_W-1){1'b0}}};
        else
            clipped = {1'b0, {(DATA_W-1){1'b1}}};
    end

    // Mode select: scaled sum or untouched capture sample.
    always_comb result = mix ? clipped : cap_data;
endmodule

// File: rtl/stmix_seq.sv
// Module: channel sequencer. Walks left then right, joins playback and
// capture for the current channel, and latches the mode at each accepted
// left sample so the right half of the pair uses the same mode.
// Assumes can_load reflects space in the output register this cycle.
module stmix_seq #(
    parameter int NUM_CH = stmix_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mix_en,
    input  logic              can_load,
    input  logic [NUM_CH-1:0] pb_valid,
    input  logic [NUM_CH-1:0] cap_valid,
    output logic [NUM_CH-1:0] pb_ready,
    output logic [NUM_CH-1:0] cap_ready,
    output logic              load,
    output logic              mix_now,
    output stmix_pkg::chan_e  phase
);
    import stmix_pkg::*;

    chan_e phase_q;
    logic  mode_q;
    logic  inputs_ok;

    // Mode in force: live enable on left, latched value on right.
    always_comb mix_now = (phase_q == CH_LEFT) ? mix_en : mode_q;

    // Current channel has all inputs it needs for this mode.
    always_comb inputs_ok = cap_valid[phase_q] && (!mix_now || pb_valid[phase_q]);

    always_comb load = can_load && inputs_ok;

    // Per-channel ready generation; bypass drains current playback lane.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cap_ready[c] = (int'(phase_q) == c) && can_load && (!mix_now || pb_valid[c]);
            pb_ready[c]  = (int'(phase_q) == c) && (!mix_now || (can_load && cap_valid[c]));
        end
    end

    // Channel phase and mode latch update on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= CH_LEFT;
            mode_q  <= 1'b0;
        end else if (load) begin
            phase_q <= (phase_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
            if (phase_q == CH_LEFT)
                mode_q <= mix_en;
        end
    end

    always_comb phase = phase_q;

    // R6
    mix_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mix_now && |(cap_ready & cap_valid)) |-> |(pb_ready & pb_valid));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && phase_q == CH_LEFT) |=> (mix_now == $past(mix_en)));
endmodule

// File: rtl/stmix_out.sv
// Module: output register for the merged stream. Holds one beat and
// keeps it stable until taken. Assumes load only when can_load is high.
module stmix_out #(
    parameter int DATA_W = stmix_pkg::SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_tid,
    output logic              can_load,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tid,
    output logic              m_tvalid,
    input  logic              m_tready
);
    // Space exists when empty or the held beat leaves this cycle.
    always_comb can_load = !m_tvalid || m_tready;

    // Beat register: capture on load, clear when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tvalid <= 1'b0;
            m_tdata  <= '0;
            m_tid    <= 1'b0;
        end else if (load) begin
            m_tvalid <= 1'b1;
            m_tdata  <= in_data;
            m_tid    <= in_tid;
        end else if (m_tready) begin
            m_tvalid <= 1'b0;
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tid)));
endmodule

// File: rtl/stereo_mix_top.sv
// Module: stereo playback/capture mixer top. Two arithmetic lanes feed a
// sequencer-selected output register that carries left and right beats
// alternately, tagged on TID. Assumes a single clock and sync reset.
module stereo_mix_top #(
    parameter int DATA_W    = stmix_pkg::SAMPLE_W,
    parameter int GAIN_FRAC = stmix_pkg::GAIN_FRAC,
    parameter int GAIN_Q    = stmix_pkg::GAIN_Q
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mix_en,
    input  logic [DATA_W-1:0] pb_l_tdata,
    input  logic              pb_l_tvalid,
    output logic              pb_l_tready,
    input  logic [DATA_W-1:0] pb_r_tdata,
    input  logic              pb_r_tvalid,
    output logic              pb_r_tready,
    input  logic [DATA_W-1:0] cap_l_tdata,
    input  logic              cap_l_tvalid,
    output logic              cap_l_tready,
    input  logic [DATA_W-1:0] cap_r_tdata,
    input  logic              cap_r_tvalid,
    output logic              cap_r_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tid,
    output logic              m_tvalid,
    input  logic              m_tready
);
    import stmix_pkg::*;
    localparam int CH = NUM_CH;

    logic [DATA_W-1:0] pb_data  [CH];
    logic [DATA_W-1:0] cap_data [CH];
    logic [DATA_W-1:0] lane_res [CH];
    logic [CH-1:0]     pb_valid, cap_valid, pb_ready, cap_ready;
    logic              can_load, load, mix_now;
    chan_e             phase;
    logic              last_tid_q;

    // Gather the per-channel ports into indexed arrays.
    always_comb begin
        pb_data[0]  = pb_l_tdata;
        pb_data[1]  = pb_r_tdata;
        cap_data[0] = cap_l_tdata;
        cap_data[1] = cap_r_tdata;
        pb_valid    = {pb_r_tvalid, pb_l_tvalid};
        cap_valid   = {cap_r_tvalid, cap_l_tvalid};
        {pb_r_tready, pb_l_tready}   = pb_ready;
        {cap_r_tready, cap_l_tready} = cap_ready;
    end

    for (genvar c = 0; c < CH; c++) begin : g_lane
        stmix_lane #(
            .DATA_W   (DATA_W),
            .GAIN_FRAC(GAIN_FRAC),
            .GAIN_Q   (GAIN_Q)
        ) u_lane (
            .mix     (mix_now),
            .pb_data (pb_data[c]),
            .cap_data(cap_data[c]),
            .result  (lane_res[c])
        );
    end

    stmix_seq #(.NUM_CH(CH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mix_en   (mix_en),
        .can_load (can_load),
        .pb_valid (pb_valid),
        .cap_valid(cap_valid),
        .pb_ready (pb_ready),
        .cap_ready(cap_ready),
        .load     (load),
        .mix_now  (mix_now),
        .phase    (phase)
    );

    stmix_out #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .in_data (lane_res[phase]),
        .in_tid  (phase == CH_RIGHT),
        .can_load(can_load),
        .m_tdata (m_tdata),
        .m_tid   (m_tid),
        .m_tvalid(m_tvalid),
        .m_tready(m_tready)
    );

    // Tag of the most recent loaded beat, for the alternation check.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_tid_q <= 1'b1;
        else if (load)   last_tid_q <= (phase == CH_RIGHT);
    end

    // R7
    tid_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (m_tid != $past(last_tid_q)));

    // R5
    bypass_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mix_now |-> (pb_ready[phase] == 1'b1));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !m_tvalid);
endmodule

// File: tb/tb_stereo_mix_top.sv
`timescale 1ns/1ps
module tb_stereo_mix_top;
    localparam int W  = 24;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mix_en = 1'b0;
    logic [W-1:0] pb_d [2];
    logic [W-1:0] cap_d [2];
    logic [1:0] pb_v = '0, cap_v = '0;
    logic pb_l_tready, pb_r_tready, cap_l_tready, cap_r_tready;
    logic [W-1:0] m_tdata;
    logic m_tid, m_tvalid;
    logic m_tready = 1'b1;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] got_d [256];
    logic         got_t [256];
    int got_n = 0;

    always #2 clk = ~clk;

    stereo_mix_top dut (
        .clk(clk), .rst_n(rst_n), .mix_en(mix_en),
        .pb_l_tdata(pb_d[0]), .pb_l_tvalid(pb_v[0]), .pb_l_tready(pb_l_tready),
        .pb_r_tdata(pb_d[1]), .pb_r_tvalid(pb_v[1]), .pb_r_tready(pb_r_tready),
        .cap_l_tdata(cap_d[0]), .cap_l_tvalid(cap_v[0]), .cap_l_tready(cap_l_tready),
        .cap_r_tdata(cap_d[1]), .cap_r_tvalid(cap_v[1]), .cap_r_tready(cap_r_tready),
        .m_tdata(m_tdata), .m_tid(m_tid), .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    // Table: {mix, pb_l, pb_r, cap_l, cap_r}
    localparam logic [96:0] VEC [NV] = '{
        {1'b1, 24'd100,    24'hFFFF9C, 24'd200,    24'd50},
        {1'b0, 24'd123456, 24'd7,      24'h400000, 24'hC00000},
        {1'b1, 24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF},
        {1'b1, 24'h800000, 24'h800000, 24'h800000, 24'h800000},
        {1'b1, 24'h7FFFFF, 24'h800000, 24'h800000, 24'h7FFFFF},
        {1'b0, 24'hABCDEF, 24'h123456, 24'h000000, 24'hFFFFFF},
        {1'b1, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h000000},
        {1'b1, 24'd3000000, 24'hD23A80, 24'd3000000, 24'hD23A80}
    };

    function automatic logic [W-1:0] model(input logic mix, input logic [W-1:0] p, input logic [W-1:0] a);
        longint s, q;
        if (!mix) return a;
        s = longint'($signed(p)) + longint'($signed(a));
        q = (s * 23198) >>> 15;
        if (q > 8388607)  q = 8388607;
        if (q < -8388608) q = -8388608;
        return q[W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Record every output handshake (sampled between edges).
    always @(negedge clk)
        if (rst_n && m_tvalid && m_tready && got_n < 256) begin
            got_d[got_n] = m_tdata;
            got_t[got_n] = m_tid;
            got_n++;
        end

    // Offer one channel's samples; return once they are consumed.
    task automatic send_chan(input int c, input logic [W-1:0] p, input logic [W-1:0] a, input bit give_pb);
        bit a_done = 0, p_done = !give_pb, af, pf;
        @(negedge clk);
        cap_d[c] = a; cap_v[c] = 1'b1;
        pb_d[c]  = p; pb_v[c]  = give_pb;
        while (!(a_done && p_done)) begin
            #0.5;
            af = cap_v[c] && (c == 0 ? cap_l_tready : cap_r_tready);
            pf = pb_v[c]  && (c == 0 ? pb_l_tready  : pb_r_tready);
            @(posedge clk); #0.5;
            if (af) begin cap_v[c] = 1'b0; a_done = 1; end
            if (pf) begin pb_v[c]  = 1'b0; p_done = 1; end
            @(negedge clk);
        end
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        logic [W-1:0] held;
        pb_d[0] = '0; pb_d[1] = '0; cap_d[0] = '0; cap_d[1] = '0;
        repeat (4) @(negedge clk);
        // R1: idle during reset and waiting on left after release
        chk(m_tvalid == 1'b0, "R1 valid in reset", m_tvalid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1 valid after reset", m_tvalid, 0);
        chk(cap_l_tready == 1'b1 && cap_r_tready == 1'b0, "R1 left first",
            {cap_r_tready, cap_l_tready}, 2'b01);

        // Table walk: R2 R3 R4 R7
        for (int i = 0; i < NV; i++) begin
            base = got_n;
            mix_en = VEC[i][96];
            send_chan(0, VEC[i][95:72], VEC[i][47:24], 1'b1);
            send_chan(1, VEC[i][71:48], VEC[i][23:0], 1'b1);
            drain();
            chk(got_n == base + 2, "R7 beat count", got_n - base, 2);
            chk(got_t[base] == 1'b0 && got_t[base+1] == 1'b1, "R7 tid order",
                {got_t[base], got_t[base+1]}, 2'b01);
            chk(got_d[base] == model(VEC[i][96], VEC[i][95:72], VEC[i][47:24]),
                VEC[i][96] ? "R2/R3 left mix" : "R4 left bypass",
                got_d[base], model(VEC[i][96], VEC[i][95:72], VEC[i][47:24]));
            chk(got_d[base+1] == model(VEC[i][96], VEC[i][71:48], VEC[i][23:0]),
                VEC[i][96] ? "R2/R3 right mix" : "R4 right bypass",
                got_d[base+1], model(VEC[i][96], VEC[i][71:48], VEC[i][23:0]));
        end

        // R3: explicit clip values
        chk(got_d[4] == 24'h7FFFFF, "R3 positive clip", got_d[4], 24'h7FFFFF);
        chk(got_d[6] == 24'h800000, "R3 negative clip", got_d[6], 24'h800000);
        // R2: floor rounding of -50 * gain gives -36
        chk(got_d[1] == 24'hFFFFDC, "R2 floor rounding", got_d[1], 24'hFFFFDC);

        // R8: enable drops between halves; right still mixes
        base = got_n;
        mix_en = 1'b1;
        send_chan(0, 24'd1000, 24'd1000, 1'b1);
        mix_en = 1'b0;
        send_chan(1, 24'd2000, 24'd2000, 1'b1);
        drain();
        chk(got_d[base+1] == model(1'b1, 24'd2000, 24'd2000), "R8 right keeps mix",
            got_d[base+1], model(1'b1, 24'd2000, 24'd2000));
        // R8: enable rises between halves; right stays bypass
        base = got_n;
        mix_en = 1'b0;
        send_chan(0, 24'd5, 24'd77, 1'b1);
        mix_en = 1'b1;
        send_chan(1, 24'd9, 24'd88, 1'b1);
        drain();
        chk(got_d[base+1] == 24'd88, "R8 right keeps bypass", got_d[base+1], 88);

        // R6: mix mode, capture valid without playback stalls
        base = got_n;
        mix_en = 1'b1;
        @(negedge clk);
        cap_d[0] = 24'd400; cap_v[0] = 1'b1;
        repeat (5) @(negedge clk);
        chk(cap_l_tready == 1'b0, "R6 capture held", cap_l_tready, 0);
        chk(got_n == base && !m_tvalid, "R6 no output", got_n - base, 0);
        cap_v[0] = 1'b0;
        send_chan(0, 24'd400, 24'd400, 1'b1);
        send_chan(1, 24'd0, 24'd0, 1'b1);
        drain();
        chk(got_d[base] == model(1'b1, 24'd400, 24'd400), "R6 joined result",
            got_d[base], model(1'b1, 24'd400, 24'd400));

        // R9 and R5: stall output in bypass
        base = got_n;
        mix_en = 1'b0;
        m_tready = 1'b0;
        send_chan(0, 24'h111111, 24'h222222, 1'b0);
        held = m_tdata;
        repeat (5) @(negedge clk);
        chk(m_tvalid && m_tdata == 24'h222222 && m_tid == 1'b0 && held == m_tdata,
            "R9 held beat", m_tdata, 24'h222222);
        chk(cap_r_tready == 1'b0, "R9 next not accepted", cap_r_tready, 0);
        chk(pb_r_tready == 1'b1, "R5 bypass drain while stalled", pb_r_tready, 1);
        m_tready = 1'b1;
        send_chan(1, 24'h333333, 24'h444444, 1'b1);
        drain();
        chk(got_n == base + 2 && got_d[base] == 24'h222222, "R9 no loss",
            got_d[base], 24'h222222);
        chk(got_d[base+1] == 24'h444444, "R5 playback ignored", got_d[base+1], 24'h444444);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule